// File: doc/BRIEF.md
# Floating-Point Register-Stack Subtract Controller

This block runs the subtract forms of a stack-organised floating-point unit. It holds eight data registers, an empty flag for each one, and a 3-bit top-of-stack pointer. Registers are named relative to that pointer: stack slot i is physical register (top + i) mod 8. An instruction arrives as an opcode byte, a ModRM byte and a memory operand. The memory operand has already been converted to the internal W-bit format, and an integer zero arrives as +0. The block decodes the form, chooses the minuend (the destination) and the subtrahend (the source), sends them through an abstract subtract stage of fixed latency `LAT`, writes the difference back, and pops the stack for the popping form.

In the abstract stage, the difference is the W-bit modular value dest - src. Its rounding indication is modelled as the borrow out of that subtraction. If any operand register is empty, the instruction raises stack underflow and leaves the stack untouched. A push port loads values onto the stack so the block can be exercised. A busy output holds off further work until the write-back has finished.

Top module: `fpsub_stack`

## Requirements
- R1: After reset, top is 0, all eight empty flags are set, c1 is 0, and busy, wrEn and stackUnderflow are all low.
- R2: A push is taken only when pushValid is high, busy is low and instValid is low. A push decrements top (mod 8), stores pushData in the new slot 0 and clears that register's empty flag. A push offered while busy, or together with instValid, changes nothing.
- R3: With mod field modrm[7:6] not equal to 3 and reg field modrm[5:3] equal to 4, each of the opcodes 0xD8, 0xDC, 0xDA and 0xDE computes slot0 - memOperand into slot 0.
- R4: Opcode 0xD8 with modrm 0xE0+i computes slot0 - slot i into slot 0.
- R5: Opcode 0xDC with modrm 0xE8+i computes slot i - slot0 into slot i.
- R6: Opcode 0xDE with modrm 0xE8+i computes slot i - slot0 into slot i and then pops. A pop sets the empty flag of the register that was slot 0 and then increments top by one. 0xDE 0xE9 is the pop form with i = 1.
- R7: An instruction is accepted on the edge where instValid is high, the encoding is valid and busy is low. busy is high from the cycle after that edge until `LAT` further edges have passed. On the last of those edges, wrEn, wrIdx (the physical destination) and wrData are presented for exactly one cycle.
- R8: An encoding outside R3 to R6, or an instruction offered while busy, is not accepted. It raises no busy signal and causes no write.
- R9: If the destination register is empty, or the source register is empty in a register form, then stackUnderflow pulses for one cycle at write-back time. In that case no write occurs, c1 is 0, and top and the empty flags are unchanged, including for a popping form.
- R10: After a successful write-back, c1 equals the borrow out of the W-bit subtraction dest - src. c1 keeps its value through pushes and ignored instructions.
- R11: Top wraps modulo 8 for pushes, pops and stack-slot indexing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction offered this cycle |
| opcode | input | 8 | Opcode byte |
| modrm | input | 8 | ModRM byte |
| memOperand | input | W | Converted memory source operand |
| pushValid | input | 1 | Push request |
| pushData | input | W | Value to push |
| busy | output | 1 | Instruction in flight |
| wrEn | output | 1 | Register write-back pulse |
| wrIdx | output | 3 | Physical register written |
| wrData | output | W | Value written |
| c1 | output | 1 | Condition bit C1 |
| stackUnderflow | output | 1 | Stack underflow pulse |
| top | output | 3 | Top-of-stack pointer |
| tagEmpty | output | 8 | Empty flag per physical register |

## Verification
An instruction is accepted on edge E0. Its write-back results (wrEn, wrIdx, wrData, c1, stackUnderflow and the updated top and empty flags) are due on edge E0+LAT. The bench samples them at the falling edge after that edge. At every falling edge in between, it checks that busy is high and that wrEn is low, then checks one cycle later that both pulses have dropped. Ignored instructions and pushes are checked at the falling edge after the edge that would have taken them. Because pushes are blocked while busy, the bench model's register contents stay valid throughout the window in which an instruction is in flight.

// File: rtl/fpsub_pkg.sv
package fpsub_pkg;
  localparam int STACK_DEPTH = 8;
  localparam int PTR_W = $clog2(STACK_DEPTH);

  typedef struct packed {
    logic             valid;
    logic             useMem;
    logic [PTR_W-1:0] dstOff;
    logic [PTR_W-1:0] srcOff;
    logic             pop;
  } decodedOp_t;

  typedef struct packed {
    logic             capture;
    logic             commit;
    logic             push;
    logic             useMem;
    logic [PTR_W-1:0] dstOff;
    logic [PTR_W-1:0] srcOff;
    logic             pop;
  } ctrlStrobes_t;
endpackage

// File: rtl/fpsub_decode.sv
module fpsub_decode
  import fpsub_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic [7:0] modrm,
  output decodedOp_t dec
);
  logic       regForm;
  logic [2:0] regField;
  logic [2:0] slotSel;

  assign regForm  = (modrm[7:6] == 2'b11);
  assign regField = modrm[5:3];
  assign slotSel  = modrm[2:0];

  always_comb begin
    dec = '0;
    if (!regForm) begin
      // memory forms: slot0 - converted memory operand
      dec.useMem = 1'b1;
      dec.valid  = (regField == 3'd4) &&
                   (opcode == 8'hD8 || opcode == 8'hDC ||
                    opcode == 8'hDA || opcode == 8'hDE);
    end else begin
      unique case (opcode)
        8'hD8: if (regField == 3'd4) begin
          dec.valid  = 1'b1;
          dec.srcOff = PTR_W'(slotSel);
        end
        8'hDC: if (regField == 3'd5) begin
          dec.valid  = 1'b1;
          dec.dstOff = PTR_W'(slotSel);
        end
        8'hDE: if (regField == 3'd5) begin
          dec.valid  = 1'b1;
          dec.dstOff = PTR_W'(slotSel);
          dec.pop    = 1'b1;
        end
        default: dec = '0;
      endcase
    end
  end
endmodule

// File: rtl/fpsub_ctrl.sv
module fpsub_ctrl
  import fpsub_pkg::*;
#(
  parameter int LAT = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         instValid,
  input  logic [7:0]   opcode,
  input  logic [7:0]   modrm,
  input  logic         pushValid,
  output logic         busy,
  output ctrlStrobes_t strobe
);
  localparam int CNT_W = $clog2(LAT + 1);

  decodedOp_t       dec;
  logic [CNT_W-1:0] remain;
  logic             accept;

  fpsub_decode dec_i (
    .opcode(opcode),
    .modrm (modrm),
    .dec   (dec)
  );

  assign busy   = (remain != '0);
  assign accept = instValid && dec.valid && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain <= '0;
    end else if (accept) begin
      remain <= CNT_W'(LAT);
    end else if (busy) begin
      remain <= remain - CNT_W'(1);
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.capture = accept;
    strobe.commit  = (remain == CNT_W'(1));
    strobe.push    = pushValid && !busy && !instValid;
    strobe.useMem  = dec.useMem;
    strobe.dstOff  = dec.dstOff;
    strobe.srcOff  = dec.srcOff;
    strobe.pop     = dec.pop;
  end
endmodule

// File: rtl/fpsub_datapath.sv
module fpsub_datapath
  import fpsub_pkg::*;
#(
  parameter int W   = 16,
  parameter int LAT = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobes_t           strobe,
  input  logic [W-1:0]           memOperand,
  input  logic [W-1:0]           pushData,
  output logic                   wrEn,
  output logic [PTR_W-1:0]       wrIdx,
  output logic [W-1:0]           wrData,
  output logic                   c1,
  output logic                   stackUnderflow,
  output logic [PTR_W-1:0]       top,
  output logic [STACK_DEPTH-1:0] tagEmpty
);
  logic [W-1:0]     regFile [STACK_DEPTH];
  logic [PTR_W-1:0] topPtr;
  logic [PTR_W-1:0] dstIdx, srcIdx, pushIdx;
  logic [W-1:0]     minuend, subtrahend;
  logic [W:0]       diffFull;
  logic             ufNow;
  logic [W:0]       stage [LAT];
  logic [PTR_W-1:0] dstIdxQ;
  logic             popQ, ufQ;

  assign dstIdx     = topPtr + strobe.dstOff;
  assign srcIdx     = topPtr + strobe.srcOff;
  assign pushIdx    = topPtr - PTR_W'(1);
  assign minuend    = regFile[dstIdx];
  assign subtrahend = strobe.useMem ? memOperand : regFile[srcIdx];
  assign diffFull   = {1'b0, minuend} - {1'b0, subtrahend};
  assign ufNow      = tagEmpty[dstIdx] || (!strobe.useMem && tagEmpty[srcIdx]);

  // abstract subtract stage: fixed-latency delay line, borrow in the top bit
  always_ff @(posedge clk) begin
    if (!rstN) stage[0] <= '0;
    else if (strobe.capture) stage[0] <= diffFull;
  end

  for (genvar k = 1; k < LAT; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) stage[k] <= '0;
      else stage[k] <= stage[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dstIdxQ <= '0;
      popQ    <= 1'b0;
      ufQ     <= 1'b0;
    end else if (strobe.capture) begin
      dstIdxQ <= dstIdx;
      popQ    <= strobe.pop;
      ufQ     <= ufNow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < STACK_DEPTH; r++) regFile[r] <= '0;
      tagEmpty       <= '1;
      topPtr         <= '0;
      c1             <= 1'b0;
      wrEn           <= 1'b0;
      wrIdx          <= '0;
      wrData         <= '0;
      stackUnderflow <= 1'b0;
    end else begin
      wrEn           <= 1'b0;
      stackUnderflow <= 1'b0;
      if (strobe.commit) begin
        if (ufQ) begin
          stackUnderflow <= 1'b1;
          c1             <= 1'b0;
        end else begin
          regFile[dstIdxQ] <= stage[LAT-1][W-1:0];
          c1               <= stage[LAT-1][W];
          wrEn             <= 1'b1;
          wrIdx            <= dstIdxQ;
          wrData           <= stage[LAT-1][W-1:0];
          if (popQ) begin
            tagEmpty[topPtr] <= 1'b1;
            topPtr           <= topPtr + PTR_W'(1);
          end
        end
      end else if (strobe.push) begin
        regFile[pushIdx]  <= pushData;
        tagEmpty[pushIdx] <= 1'b0;
        topPtr            <= pushIdx;
      end
    end
  end

  assign top = topPtr;
endmodule

// File: rtl/fpsub_stack.sv
module fpsub_stack
  import fpsub_pkg::*;
#(
  parameter int W   = 16,
  parameter int LAT = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         instValid,
  input  logic [7:0]   opcode,
  input  logic [7:0]   modrm,
  input  logic [W-1:0] memOperand,
  input  logic         pushValid,
  input  logic [W-1:0] pushData,
  output logic         busy,
  output logic         wrEn,
  output logic [2:0]   wrIdx,
  output logic [W-1:0] wrData,
  output logic         c1,
  output logic         stackUnderflow,
  output logic [2:0]   top,
  output logic [7:0]   tagEmpty
);
  ctrlStrobes_t strobe;

  fpsub_ctrl #(.LAT(LAT)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .instValid(instValid),
    .opcode   (opcode),
    .modrm    (modrm),
    .pushValid(pushValid),
    .busy     (busy),
    .strobe   (strobe)
  );

  fpsub_datapath #(.W(W), .LAT(LAT)) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .memOperand    (memOperand),
    .pushData      (pushData),
    .wrEn          (wrEn),
    .wrIdx         (wrIdx),
    .wrData        (wrData),
    .c1            (c1),
    .stackUnderflow(stackUnderflow),
    .top           (top),
    .tagEmpty      (tagEmpty)
  );
endmodule

// File: rtl/fpsub_stack_chk.sv
module fpsub_stack_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       wrEn,
  input logic       c1,
  input logic       stackUnderflow,
  input logic [2:0] top,
  input logic [7:0] tagEmpty
);
  // R9
  uf_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    stackUnderflow |-> !wrEn);
  // R9
  uf_c1_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stackUnderflow |-> !c1);
  // R9
  uf_state_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    stackUnderflow |-> ($stable(top) && $stable(tagEmpty)));
  // R7
  write_from_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn || stackUnderflow) |-> $past(busy));
  // R7
  busy_ends_in_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (wrEn || stackUnderflow));
  // R6
  pop_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (top != $past(top))) |-> (top == $past(top) + 3'd1));
  // R6
  pop_marks_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (top != $past(top))) |-> tagEmpty[$past(top)]);
endmodule

bind fpsub_stack fpsub_stack_chk chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .busy          (busy),
  .wrEn          (wrEn),
  .c1            (c1),
  .stackUnderflow(stackUnderflow),
  .top           (top),
  .tagEmpty      (tagEmpty)
);

// File: tb/fpsub_stack_tb.sv
module fpsub_stack_tb_top;
  localparam int W   = 16;
  localparam int LAT = 3;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         instValid = 1'b0;
  logic [7:0]   opcode = '0;
  logic [7:0]   modrm = '0;
  logic [W-1:0] memOperand = '0;
  logic         pushValid = 1'b0;
  logic [W-1:0] pushData = '0;
  logic         busy, wrEn, c1, stackUnderflow;
  logic [2:0]   wrIdx, top;
  logic [W-1:0] wrData;
  logic [7:0]   tagEmpty;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [W-1:0] mReg [8];
  logic [7:0]   mEmpty;
  logic [2:0]   mTop;
  logic         mC1;

  always #10 clk = ~clk;

  fpsub_stack #(.W(W), .LAT(LAT)) dut_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .opcode(opcode),
    .modrm(modrm), .memOperand(memOperand), .pushValid(pushValid),
    .pushData(pushData), .busy(busy), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrData(wrData), .c1(c1), .stackUnderflow(stackUnderflow),
    .top(top), .tagEmpty(tagEmpty)
  );

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkState(input string req);
    chkEq({req, " top"}, 32'(top), 32'(mTop));
    chkEq({req, " tags"}, 32'(tagEmpty), 32'(mEmpty));
    chkEq({req, " c1"}, 32'(c1), 32'(mC1));
  endtask

  function automatic bit mDecode(input logic [7:0] op, input logic [7:0] m,
                                 output bit isMem, output logic [2:0] d,
                                 output logic [2:0] s, output bit pop);
    isMem = 1'b0; d = '0; s = '0; pop = 1'b0;
    if (m[7:6] != 2'b11) begin
      isMem = 1'b1;
      return (m[5:3] == 3'd4) && (op == 8'hD8 || op == 8'hDC || op == 8'hDA || op == 8'hDE);
    end
    if (op == 8'hD8 && m[5:3] == 3'd4) begin s = m[2:0]; return 1'b1; end
    if ((op == 8'hDC || op == 8'hDE) && m[5:3] == 3'd5) begin
      d = m[2:0]; pop = (op == 8'hDE); return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic pushVal(input logic [W-1:0] v);
    @(negedge clk);
    pushValid = 1'b1; pushData = v;
    @(negedge clk);
    pushValid = 1'b0;
    mTop = mTop - 3'd1;
    mReg[mTop] = v;
    mEmpty[mTop] = 1'b0;
    chkState("R2 R10 R11 push");
  endtask

  // pushMode: 0 none, 1 push together with instValid, 2 push while busy
  task automatic runInst(input string req, input logic [7:0] op, input logic [7:0] m,
                         input logic [W-1:0] memv, input int pushMode);
    bit ok, isMem, pop, uf;
    logic [2:0] d, s, di, si;
    logic [W-1:0] a, b;
    logic [W:0] full;
    ok = mDecode(op, m, isMem, d, s, pop);
    @(negedge clk);
    instValid = 1'b1; opcode = op; modrm = m; memOperand = memv;
    if (pushMode == 1) begin pushValid = 1'b1; pushData = 16'hBEEF; end
    @(negedge clk);
    instValid = 1'b0;
    pushValid = (pushMode == 2);
    pushData = 16'hCAFE;
    if (!ok) begin
      pushValid = 1'b0;
      chkEq({req, " R8 not accepted"}, 32'(busy), 0);
      for (int k = 0; k < LAT + 1; k++) begin
        @(negedge clk);
        chkEq({req, " R8 no write"}, 32'(wrEn), 0);
      end
      chkState({req, " R8"});
      return;
    end
    chkEq({req, " R7 busy"}, 32'(busy), 1);
    di = mTop + d; si = mTop + s;
    a = mReg[di];
    b = isMem ? memv : mReg[si];
    uf = mEmpty[di] || (!isMem && mEmpty[si]);
    full = {1'b0, a} - {1'b0, b};
    for (int k = 1; k <= LAT; k++) begin
      @(negedge clk);
      pushValid = 1'b0;
      if (k < LAT) begin
        chkEq({req, " R7 busy held"}, 32'(busy), 1);
        chkEq({req, " R7 early write"}, 32'(wrEn), 0);
      end
    end
    chkEq({req, " R7 busy done"}, 32'(busy), 0);
    if (uf) begin
      mC1 = 1'b0;
      chkEq({req, " R9 underflow"}, 32'(stackUnderflow), 1);
      chkEq({req, " R9 no write"}, 32'(wrEn), 0);
    end else begin
      mReg[di] = full[W-1:0];
      mC1 = full[W];
      if (pop) begin mEmpty[mTop] = 1'b1; mTop = mTop + 3'd1; end
      chkEq({req, " underflow low"}, 32'(stackUnderflow), 0);
      chkEq({req, " R7 wrEn"}, 32'(wrEn), 1);
      chkEq({req, " wrIdx"}, 32'(wrIdx), 32'(di));
      chkEq({req, " wrData"}, 32'(wrData), 32'(full[W-1:0]));
    end
    chkState({req, " R10 R11"});
    @(negedge clk);
    chkEq({req, " R7 pulse one cycle"}, 32'(wrEn | stackUnderflow), 0);
  endtask

  initial begin
    for (int r = 0; r < 8; r++) mReg[r] = '0;
    mEmpty = 8'hFF; mTop = 3'd0; mC1 = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chkEq("R1 busy", 32'(busy), 0);
    chkEq("R1 wrEn", 32'(wrEn), 0);
    chkEq("R1 underflow", 32'(stackUnderflow), 0);
    chkState("R1");

    // R9 empty stack
    runInst("R9 R4 empty", 8'hD8, 8'hE1, '0, 0);
    runInst("R9 R3 empty mem", 8'hDA, 8'h20, 16'h0010, 0);

    // R2 R11 fill all eight slots, top wraps 0 -> 7 -> ... -> 0
    for (int k = 0; k < 8; k++) pushVal(16'(k * 16'h1357 + 5));

    // R4 every slot
    for (int i = 0; i < 8; i++) runInst("R4 d8", 8'hD8, 8'hE0 + 8'(i), '0, 0);
    // R5 every slot
    for (int i = 0; i < 8; i++) runInst("R5 dc", 8'hDC, 8'hE8 + 8'(i), '0, 0);

    // R3 memory forms, several mod/rm values, values above and below
    runInst("R3 d8 mem", 8'hD8, 8'h20, 16'h0100, 0);
    runInst("R3 dc mem", 8'hDC, 8'h64, 16'hFF00, 0);
    runInst("R3 da mem", 8'hDA, 8'hA5, 16'h0003, 0);
    runInst("R3 de mem", 8'hDE, 8'h27, 16'h8001, 0);

    // R8 encodings outside the forms
    runInst("R8 d8 reg1", 8'hD8, 8'h08, '0, 0);
    runInst("R8 dc e0", 8'hDC, 8'hE0, '0, 0);
    runInst("R8 da e8", 8'hDA, 8'hE8, '0, 0);
    runInst("R8 d9", 8'hD9, 8'h20, '0, 0);
    runInst("R8 de e0", 8'hDE, 8'hE0, '0, 0);

    // R2 pushes ignored with instValid or while busy
    runInst("R2 push with inst", 8'hD8, 8'hE3, '0, 1);
    runInst("R2 push while busy", 8'hDC, 8'hE6, '0, 2);

    // R8 instruction offered while busy is dropped
    @(negedge clk);
    instValid = 1'b1; opcode = 8'hD8; modrm = 8'hE2;
    @(negedge clk);
    modrm = 8'hE5;
    @(negedge clk);
    instValid = 1'b0;
    repeat (LAT) @(negedge clk);
    begin
      logic [W:0] full;
      full = {1'b0, mReg[mTop]} - {1'b0, mReg[mTop + 3'd2]};
      chkEq("R8 only first accepted wrData", 32'(wrData), 32'(full[W-1:0]));
      mReg[mTop] = full[W-1:0]; mC1 = full[W];
    end
    @(negedge clk);
    chkEq("R8 second not started", 32'(busy | wrEn), 0);
    chkState("R8 busy drop");

    // R6 pops, including underflow once the stack runs short
    for (int k = 0; k < 12; k++)
      runInst("R6 de pop", 8'hDE, 8'hE8 + 8'((k % 3) + 1), '0, 0);
    runInst("R6 de e9", 8'hDE, 8'hE9, '0, 0);
    runInst("R6 de e8", 8'hDE, 8'hE8, '0, 0);
    runInst("R9 after drain", 8'hD8, 8'h20, 16'h0001, 0);
    pushVal(16'h0002);
    runInst("R10 borrow", 8'hD8, 8'h20, 16'h0005, 0);
    runInst("R6 final pop wrap", 8'hDE, 8'hE8, '0, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule